// File: doc/BRIEF.md
# Load Address and Base Update Unit

This unit forms the memory address for a single-register load and the updated base value that goes with it. A load is issued with a 32-bit instruction word, the current value of the base register and an offset from an external shifter. From these the unit decides four things. The offset is either a 12-bit literal taken from the instruction or the shifter's value. It is added or subtracted. It is applied before the access (pre-indexed) or after it (post-indexed). The access is a full word or a single byte.

The unit then runs one access to a memory model over a request/valid handshake and waits for the read data. On completion it reports, all in one cycle:
- the destination write, with a byte zero-extended to the full width;
- the base writeback, when one is due;
- a pipeline refill request, when a word is loaded into the program counter;
- the cycle cost of the instruction.

Top module: `ld_addr_gen`

## Requirements
- R1: While reset is held and after it is released, `mem_req_o`, `rd_we_o`, `wb_we_o` and `refill_o` are 0 until a load is issued.
- R2: With instruction bit 24 = 1 (pre-indexed), `mem_addr_o` is base + offset when bit 23 = 1 and base − offset when bit 23 = 0.
- R3: A pre-indexed load writes back the base, with `wb_data_o` equal to the access address, only when instruction bit 21 = 1. With bit 21 = 0, `wb_we_o` stays 0.
- R4: With bit 24 = 0 (post-indexed), `mem_addr_o` equals the unmodified base, and the base is always written back as base + offset (bit 23 = 1) or base − offset (bit 23 = 0).
- R5: With bit 25 = 0 the offset is instruction bits 11:0, zero-extended. With bit 25 = 1 it is `shifted_i`.
- R6: With bit 22 = 1, `mem_byte_o` is 1 and `rd_data_o` is bits 7:0 of the read data, zero-extended. With bit 22 = 0 it is the full read word.
- R7: `refill_o` pulses with completion when a word load has destination field bits 15:12 equal to 15. A byte load never raises it.
- R8: When the destination field equals the base field (bits 19:16), no base writeback occurs and `rd_data_o` carries the loaded value.
- R9: `cost_o` reports 3 for an immediate-offset load and 1 for a register-offset load.
- R10: Address and writeback arithmetic wrap modulo 2^32.
- R11: `mem_req_o` stays high with a stable `mem_addr_o` until `mem_valid_i`. The completion (`rd_we_o`) pulses for one cycle in the next cycle. An `issue_i` raised while an access is outstanding is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue_i | input | 1 | Start a load (taken when idle) |
| instr_i | input | 32 | Instruction word |
| base_i | input | 32 | Base register value |
| shifted_i | input | 32 | Shifted register offset from external shifter |
| mem_req_o | output | 1 | Memory read request |
| mem_addr_o | output | 32 | Access address |
| mem_byte_o | output | 1 | 1 = byte access, 0 = word |
| mem_valid_i | input | 1 | Read data valid |
| mem_rdata_i | input | 32 | Read data (byte in bits 7:0) |
| rd_we_o | output | 1 | Destination write strobe, marks completion |
| rd_idx_o | output | 4 | Destination register index |
| rd_data_o | output | 32 | Value for destination |
| wb_we_o | output | 1 | Base writeback strobe |
| wb_idx_o | output | 4 | Base register index |
| wb_data_o | output | 32 | Updated base value |
| refill_o | output | 1 | Pipeline refill request |
| cost_o | output | 2 | Cycle count reported for the load |

## Verification
The destination write and the base writeback complete in the same cycle. When both name one register, only the loaded data may reach it. The bench provokes this with a post-indexed load, where writeback is forced, whose destination field equals its base field. It judges the result by requiring `wb_we_o` low while `rd_we_o` is high, with `rd_data_o` equal to the word the memory model returns. A second overlap puts a refill request on the same completion as a writeback. That case is judged by checking both strobes together.

// File: rtl/ldag_pkg.sv
package ldag_pkg;
   localparam int INSTR_W = 32;
   localparam int IDX_W   = 4;
   localparam int IMM_W   = 12;

   // Instruction bit positions that steer behaviour
   localparam int B_REGOFF = 25;
   localparam int B_PRE    = 24;
   localparam int B_UP     = 23;
   localparam int B_BYTE   = 22;
   localparam int B_WBACK  = 21;
   localparam int B_BASE   = 16;
   localparam int B_DST    = 12;

   typedef struct packed {
      logic             reg_off;
      logic             pre;
      logic             up;
      logic             byte_sz;
      logic             wback;
      logic [IDX_W-1:0] base_idx;
      logic [IDX_W-1:0] dst_idx;
      logic [IMM_W-1:0] imm;
   } ld_fields_t;

   typedef enum logic {S_IDLE = 1'b0, S_WAIT = 1'b1} ld_state_e;
endpackage

// File: rtl/ldag_decode.sv
module ldag_decode
   import ldag_pkg::*;
(
   input  logic [INSTR_W-1:0] instr_i,
   output ld_fields_t         fields_o
);
   logic unused_bits;
   assign unused_bits = ^{instr_i[INSTR_W-1:B_REGOFF+1], instr_i[B_WBACK-1:B_BASE+IDX_W]};

   always_comb begin
      fields_o.reg_off  = instr_i[B_REGOFF];
      fields_o.pre      = instr_i[B_PRE];
      fields_o.up       = instr_i[B_UP];
      fields_o.byte_sz  = instr_i[B_BYTE];
      fields_o.wback    = instr_i[B_WBACK];
      fields_o.base_idx = instr_i[B_BASE +: IDX_W];
      fields_o.dst_idx  = instr_i[B_DST +: IDX_W];
      fields_o.imm      = instr_i[IMM_W-1:0];
   end
endmodule

// File: rtl/ldag_offset_adder.sv
module ldag_offset_adder #(
   parameter int XLEN          = 32,
   parameter bit SINGLE_ADDER  = 1'b1
) (
   input  logic [XLEN-1:0] base_i,
   input  logic [XLEN-1:0] offset_i,
   input  logic            up_i,
   output logic [XLEN-1:0] sum_o
);
   generate
      if (SINGLE_ADDER) begin : g_one
         logic [XLEN-1:0] opnd;
         assign opnd  = up_i ? offset_i : ~offset_i;
         assign sum_o = base_i + opnd + {{(XLEN-1){1'b0}}, ~up_i};
      end else begin : g_two
         logic [XLEN-1:0] plus, minus;
         assign plus  = base_i + offset_i;
         assign minus = base_i - offset_i;
         assign sum_o = up_i ? plus : minus;
      end
   endgenerate
endmodule

// File: rtl/ldag_result.sv
module ldag_result #(
   parameter int XLEN = 32
) (
   input  logic            byte_sz_i,
   input  logic [XLEN-1:0] rdata_i,
   output logic [XLEN-1:0] value_o
);
   always_comb begin
      if (byte_sz_i) value_o = {{(XLEN-8){1'b0}}, rdata_i[7:0]};
      else           value_o = rdata_i;
   end
endmodule

// File: rtl/ld_addr_gen.sv
module ld_addr_gen
   import ldag_pkg::*;
#(
   parameter int XLEN         = 32,
   parameter int PC_IDX       = 15,
   parameter int CYC_IMM      = 3,
   parameter int CYC_REG      = 1,
   parameter bit SINGLE_ADDER = 1'b1,
   localparam int CYC_MAX     = (CYC_IMM > CYC_REG) ? CYC_IMM : CYC_REG,
   localparam int CYC_W       = $clog2(CYC_MAX + 1)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 issue_i,
   input  logic [INSTR_W-1:0]   instr_i,
   input  logic [XLEN-1:0]      base_i,
   input  logic [XLEN-1:0]      shifted_i,
   output logic                 mem_req_o,
   output logic [XLEN-1:0]      mem_addr_o,
   output logic                 mem_byte_o,
   input  logic                 mem_valid_i,
   input  logic [XLEN-1:0]      mem_rdata_i,
   output logic                 rd_we_o,
   output logic [IDX_W-1:0]     rd_idx_o,
   output logic [XLEN-1:0]      rd_data_o,
   output logic                 wb_we_o,
   output logic [IDX_W-1:0]     wb_idx_o,
   output logic [XLEN-1:0]      wb_data_o,
   output logic                 refill_o,
   output logic [CYC_W-1:0]     cost_o
);
   generate
      if (XLEN < 16)            begin : g_bad_xlen  $error("XLEN must hold the 12-bit literal and a byte"); end
      if (CYC_IMM < 1 || CYC_REG < 1) begin : g_bad_cyc $error("cycle costs must be positive"); end
      if (PC_IDX < 0 || PC_IDX >= (1 << IDX_W)) begin : g_bad_pc $error("PC_IDX out of range"); end
   endgenerate

   ld_fields_t      fld;
   logic [XLEN-1:0] offset, sum, loaded;
   ld_state_e       state_q;

   logic            wben_q, refill_pend_q;
   logic [XLEN-1:0] addr_q, wbv_q, rd_data_q;
   logic [IDX_W-1:0] rd_idx_q, base_idx_q;
   logic            byte_q, req_q, rd_we_q, wb_we_q, refill_q;
   logic [CYC_W-1:0] cost_q;

   ldag_decode u_dec (.instr_i(instr_i), .fields_o(fld));

   assign offset = fld.reg_off ? shifted_i : {{(XLEN-IMM_W){1'b0}}, fld.imm};

   ldag_offset_adder #(.XLEN(XLEN), .SINGLE_ADDER(SINGLE_ADDER)) u_add (
      .base_i(base_i), .offset_i(offset), .up_i(fld.up), .sum_o(sum));

   ldag_result #(.XLEN(XLEN)) u_res (
      .byte_sz_i(byte_q), .rdata_i(mem_rdata_i), .value_o(loaded));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q       <= S_IDLE;
         req_q         <= 1'b0;
         addr_q        <= '0;
         byte_q        <= 1'b0;
         wbv_q         <= '0;
         wben_q        <= 1'b0;
         refill_pend_q <= 1'b0;
         rd_idx_q      <= '0;
         base_idx_q    <= '0;
         cost_q        <= '0;
         rd_we_q       <= 1'b0;
         rd_data_q     <= '0;
         wb_we_q       <= 1'b0;
         refill_q      <= 1'b0;
      end else begin
         rd_we_q  <= 1'b0;
         wb_we_q  <= 1'b0;
         refill_q <= 1'b0;
         if (state_q == S_IDLE) begin
            if (issue_i) begin
               state_q       <= S_WAIT;
               req_q         <= 1'b1;
               addr_q        <= fld.pre ? sum : base_i;
               byte_q        <= fld.byte_sz;
               wbv_q         <= sum;
               wben_q        <= ~fld.pre | fld.wback;
               refill_pend_q <= ~fld.byte_sz & (fld.dst_idx == IDX_W'(PC_IDX));
               rd_idx_q      <= fld.dst_idx;
               base_idx_q    <= fld.base_idx;
               cost_q        <= fld.reg_off ? CYC_W'(CYC_REG) : CYC_W'(CYC_IMM);
            end
         end else if (mem_valid_i) begin
            state_q   <= S_IDLE;
            req_q     <= 1'b0;
            rd_we_q   <= 1'b1;
            rd_data_q <= loaded;
            wb_we_q   <= wben_q & (base_idx_q != rd_idx_q);
            refill_q  <= refill_pend_q;
         end
      end
   end

   assign mem_req_o  = req_q;
   assign mem_addr_o = addr_q;
   assign mem_byte_o = byte_q;
   assign rd_we_o    = rd_we_q;
   assign rd_idx_o   = rd_idx_q;
   assign rd_data_o  = rd_data_q;
   assign wb_we_o    = wb_we_q;
   assign wb_idx_o   = base_idx_q;
   assign wb_data_o  = wbv_q;
   assign refill_o   = refill_q;
   assign cost_o     = cost_q;

   // R11: request and address hold until the memory answers
   p_addr_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_o && !mem_valid_i) |=> (mem_req_o && $stable(mem_addr_o)));

   // R11: answer leads to a completion in the following cycle
   p_done_after_valid_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_o && mem_valid_i) |=> (rd_we_o && !mem_req_o));

   // R11: completion is a single-cycle pulse
   p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
      rd_we_o |=> !rd_we_o);

   // R8: writeback never targets the destination register
   p_no_clash_r8: assert property (@(posedge clk) disable iff (!rst_n)
      wb_we_o |-> (rd_we_o && (wb_idx_o != rd_idx_o)));

   // R6: byte results carry no upper bits
   p_byte_zext_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_we_o && mem_byte_o) |-> (rd_data_o[XLEN-1:8] == '0));

   // R7: refill only with a word completion
   p_refill_word_r7: assert property (@(posedge clk) disable iff (!rst_n)
      refill_o |-> (rd_we_o && !mem_byte_o && rd_idx_o == IDX_W'(PC_IDX)));
endmodule

// File: tb/ld_addr_gen_tb_top.sv
module ld_addr_gen_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        issue_i = 1'b0;
   logic [31:0] instr_i = '0;
   logic [31:0] base_i = '0;
   logic [31:0] shifted_i = '0;
   logic        mem_req_o, mem_byte_o, mem_valid_i, rd_we_o, wb_we_o, refill_o;
   logic [31:0] mem_addr_o, mem_rdata_i, rd_data_o, wb_data_o;
   logic [3:0]  rd_idx_o, wb_idx_o;
   logic [1:0]  cost_o;

   int checks = 0;
   int errors = 0;
   int lat    = 0;
   int wcnt   = 0;

   always #5 clk = ~clk;

   ld_addr_gen dut_i (
      .clk(clk), .rst_n(rst_n), .issue_i(issue_i), .instr_i(instr_i),
      .base_i(base_i), .shifted_i(shifted_i), .mem_req_o(mem_req_o),
      .mem_addr_o(mem_addr_o), .mem_byte_o(mem_byte_o), .mem_valid_i(mem_valid_i),
      .mem_rdata_i(mem_rdata_i), .rd_we_o(rd_we_o), .rd_idx_o(rd_idx_o),
      .rd_data_o(rd_data_o), .wb_we_o(wb_we_o), .wb_idx_o(wb_idx_o),
      .wb_data_o(wb_data_o), .refill_o(refill_o), .cost_o(cost_o));

   function automatic logic [31:0] memval(input logic [31:0] a);
      return a ^ 32'hDEAD_BE81;
   endfunction

   // Memory model: answers after lat idle cycles of request
   always @(posedge clk) begin
      if (!rst_n) begin
         mem_valid_i <= 1'b0;
         mem_rdata_i <= '0;
         wcnt        <= 0;
      end else begin
         mem_valid_i <= 1'b0;
         if (mem_req_o && !mem_valid_i) begin
            if (wcnt >= lat) begin
               mem_valid_i <= 1'b1;
               mem_rdata_i <= memval(mem_addr_o);
               wcnt        <= 0;
            end else begin
               wcnt <= wcnt + 1;
            end
         end
      end
   end

   function automatic logic [31:0] mk(input logic regoff, pre, up, byt, wb,
                                      input logic [3:0] bidx, didx,
                                      input logic [11:0] low);
      logic [31:0] w;
      w = 32'hE000_0000 | {12'h0, bidx, didx, low};
      w[25] = regoff; w[24] = pre; w[23] = up; w[22] = byt; w[21] = wb;
      return w;
   endfunction

   task automatic chk(input string req, input string what, input logic [31:0] act, exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   // Issue one load and check address phase and completion
   task automatic run_load(input string req, input logic [31:0] ins, base, sh,
                           input logic [31:0] e_addr, e_data,
                           input logic e_byte, e_wbwe, input logic [31:0] e_wbdata,
                           input logic e_refill, input logic [1:0] e_cost);
      int n;
      @(negedge clk);
      instr_i = ins; base_i = base; shifted_i = sh; issue_i = 1'b1;
      @(negedge clk);
      issue_i = 1'b0;
      chk(req, "req", {31'h0, mem_req_o}, 32'h1);
      chk(req, "addr", mem_addr_o, e_addr);
      chk(req, "byte", {31'h0, mem_byte_o}, {31'h0, e_byte});
      n = 0;
      while (!rd_we_o && n < 50) begin @(negedge clk); n++; end
      chk(req, "done", {31'h0, rd_we_o}, 32'h1);
      chk(req, "rd_idx", {28'h0, rd_idx_o}, {28'h0, ins[15:12]});
      chk(req, "rd_data", rd_data_o, e_data);
      chk(req, "wb_we", {31'h0, wb_we_o}, {31'h0, e_wbwe});
      if (e_wbwe) begin
         chk(req, "wb_data", wb_data_o, e_wbdata);
         chk(req, "wb_idx", {28'h0, wb_idx_o}, {28'h0, ins[19:16]});
      end
      chk(req, "refill", {31'h0, refill_o}, {31'h0, e_refill});
      chk(req, "cost", {30'h0, cost_o}, {30'h0, e_cost});
      @(negedge clk);
      chk(req, "done_pulse", {31'h0, rd_we_o}, 32'h0);
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      chk("R1", "req_rst", {31'h0, mem_req_o}, 32'h0);
      chk("R1", "we_rst", {29'h0, rd_we_o, wb_we_o, refill_o}, 32'h0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk("R1", "idle_after", {28'h0, mem_req_o, rd_we_o, wb_we_o, refill_o}, 32'h0);
   endtask

   task automatic t_pre_up_imm();   // R2 R3 R5 R9
      run_load("R2", mk(0,1,1,0,1, 4'd2, 4'd3, 12'h024), 32'h1000, 32'hFFFF, 32'h1024,
               memval(32'h1024), 0, 1, 32'h1024, 0, 2'd3);
   endtask

   task automatic t_pre_down_reg_nowb();   // R2 R3 R5 R9
      run_load("R3", mk(1,1,0,0,0, 4'd4, 4'd5, 12'h7FF), 32'h2000, 32'h10, 32'h1FF0,
               memval(32'h1FF0), 0, 0, 32'h0, 0, 2'd1);
   endtask

   task automatic t_post_up_reg();   // R4 R5
      run_load("R4", mk(1,0,1,0,0, 4'd6, 4'd7, 12'h001), 32'h3000, 32'h40, 32'h3000,
               memval(32'h3000), 0, 1, 32'h3040, 0, 2'd1);
   endtask

   task automatic t_post_down_wrap();   // R4 R10
      run_load("R10", mk(0,0,0,0,0, 4'd1, 4'd9, 12'hFFF), 32'h100, 32'h0, 32'h100,
               memval(32'h100), 0, 1, 32'hFFFF_F101, 0, 2'd3);
   endtask

   task automatic t_pre_up_wrap();   // R10
      run_load("R10", mk(1,1,1,0,1, 4'd8, 4'd10, 12'h0), 32'hFFFF_FFF0, 32'h20, 32'h10,
               memval(32'h10), 0, 1, 32'h10, 0, 2'd1);
   endtask

   task automatic t_byte_pc();   // R6 R7: byte to dest 15 zero-extends, no refill
      run_load("R6", mk(0,1,1,1,0, 4'd2, 4'd15, 12'h003), 32'h4000, 32'h0, 32'h4003,
               {24'h0, 8'h03 ^ 8'h81}, 1, 0, 32'h0, 0, 2'd3);
   endtask

   task automatic t_word_pc();   // R7 with writeback in the same completion
      run_load("R7", mk(1,1,0,0,1, 4'd11, 4'd15, 12'h0), 32'h5008, 32'h8, 32'h5000,
               memval(32'h5000), 0, 1, 32'h5000, 1, 2'd1);
   endtask

   task automatic t_clash();   // R8: post-indexed, dest == base
      run_load("R8", mk(0,0,1,0,0, 4'd3, 4'd3, 12'h010), 32'h6000, 32'h0, 32'h6000,
               memval(32'h6000), 0, 0, 32'h0, 0, 2'd3);
   endtask

   task automatic t_latency_ignore();   // R11
      int n;
      lat = 3;
      @(negedge clk);
      instr_i = mk(0,1,1,0,0, 4'd1, 4'd2, 12'h004); base_i = 32'h7000; issue_i = 1'b1;
      @(negedge clk);
      instr_i = mk(0,1,1,0,0, 4'd1, 4'd2, 12'h100); base_i = 32'h9000;
      @(negedge clk);
      issue_i = 1'b0;
      chk("R11", "addr_held", mem_addr_o, 32'h7004);
      chk("R11", "req_held", {31'h0, mem_req_o}, 32'h1);
      n = 0;
      while (!rd_we_o && n < 50) begin @(negedge clk); n++; end
      chk("R11", "done_late", {31'h0, rd_we_o}, 32'h1);
      chk("R11", "data_first", rd_data_o, memval(32'h7004));
      @(negedge clk);
      chk("R11", "no_second", {30'h0, mem_req_o, rd_we_o}, 32'h0);
      lat = 0;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      t_reset();
      t_pre_up_imm();
      t_pre_down_reg_nowb();
      t_post_up_reg();
      t_post_down_wrap();
      t_pre_up_wrap();
      t_byte_pc();
      t_word_pc();
      t_clash();
      t_latency_ignore();
      repeat (2) @(negedge clk);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule